// File: doc/BRIEF.md
# Resumable Multi-Register Transfer Sequencer

This control block turns one load-multiple or store-multiple command, given as a register mask, into a run of single-word bus beats. It can also run a doubleword load or store. A command is accepted only while the block is idle. The block then holds `busy_o` for the whole operation, so the surrounding pipeline cannot issue the instruction before or after it in parallel. The first cycle after acceptance computes the address and does no bus transfer. After that cycle, one beat is issued per cycle. A bus wait state stretches the current beat.

During a list transfer, an interrupt request may stop the operation after any completed beat that is not the last one. The block then publishes the index of the next untransferred register. A later command with the resume flag set continues from that register, at the address it would have had in the uninterrupted run. A restart costs `RESUME_EXTRA` additional cycles before its first beat. The register-file data, base writeback and exception return belong to neighbouring logic.

Top module: `mxfer_seq`

## Requirements
- R1: After synchronous active-low reset, `busy_o`, `bus_req_o`, `bus_we_o`, `rf_we_o`, `done_o` and `halt_o` are 0, and `resume_idx_o` is 0.
- R2: `start_i` is sampled only when `busy_o` is 0. `busy_o` rises in the cycle after acceptance. A `start_i` pulse during an operation leaves that operation's trace unchanged.
- R3: Selected registers are transferred in ascending index order. The k-th set bit of the mask (counting from 0 at bit 0) uses address `base_i + WORD_BYTES*k`, and `reg_idx_o` shows that bit's index.
- R4: A fresh N-element operation with no wait states stays busy for N+1 cycles. The first busy cycle has no bus request, and each later cycle completes one beat.
- R5: `busy_o` stays 1 from the cycle after acceptance through the final beat or stop cycle, and is 0 in the cycle after that.
- R6: With `store_i`=1, every beat drives `bus_we_o`=1 and `rf_we_o` stays 0. With `store_i`=0, `bus_we_o` is 0 and `rf_we_o` is 1 exactly in beat cycles where `bus_wait_i` is 0.
- R7: While `bus_wait_i` is 1 during a beat, the beat repeats with the same address and register index, and nothing completes.
- R8: During a list transfer, `irq_i`=1 in a completing beat that is not the last one pulses `halt_o` in that cycle. The block then goes idle, and `resume_idx_o` holds the next set-bit index. `irq_i` has no effect in non-completing cycles.
- R9: A list command with `resume_i`=1 starts at the lowest set bit whose index is at least `resume_idx_i`. Its address is `base_i + WORD_BYTES*(set bits below that index)`. Its first beat comes after 1+`RESUME_EXTRA` busy cycles with no bus request.
- R10: With `pair_i`=1, only the two lowest set bits are transferred, in 3 cycles when unstalled. `irq_i` and `resume_i` have no effect on it.
- R11: `done_o` pulses with the final completing beat, and `resume_idx_o` then reads NREG (16). If no register is selected, `done_o` pulses in the single setup cycle and no beat is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Command request, sampled while idle |
| pair_i | input | 1 | Doubleword mode: lowest two set bits only |
| store_i | input | 1 | 1 = store (memory write), 0 = load |
| resume_i | input | 1 | Continue a stopped list from `resume_idx_i` |
| resume_idx_i | input | 5 | Restart register index |
| base_i | input | 32 | Base word address |
| mask_i | input | 16 | Register selection mask, bit n = register n |
| bus_wait_i | input | 1 | Bus wait state for the current beat |
| irq_i | input | 1 | Interrupt request |
| busy_o | output | 1 | Operation in progress, blocks neighbours |
| bus_req_o | output | 1 | Beat presented this cycle |
| bus_addr_o | output | 32 | Beat address |
| bus_we_o | output | 1 | Beat is a memory write |
| reg_idx_o | output | 4 | Register index of the beat |
| rf_we_o | output | 1 | Register-file write for a completed load beat |
| done_o | output | 1 | Operation finished this cycle |
| halt_o | output | 1 | Operation stopped for an interrupt this cycle |
| resume_idx_o | output | 5 | Next untransferred register index |

## Verification
The bench builds the block with its defaults: 16 registers, 32-bit addresses, 4-byte words and a two-cycle restart cost. With these values the full 0xFFFF mask, the exhausted-list value 16 on the resume index, and restart-cost counting can all be reached. Random masks are mixed with random wait and interrupt densities. Each interrupted run is resumed from the index the block reported, so the stop and restart paths are exercised at every list position.

// File: rtl/mxs_pkg.sv
// Shared types for the multi-register transfer sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package mxs_pkg;

    // Controller phases: idle, address setup, restart penalty, beat issue
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_RESTART = 2'd2,
        ST_XFER    = 2'd3
    } mxs_state_e;

    // Per-beat decision produced by the controller for the current cycle
    typedef struct packed {
        logic complete;
        logic last;
        logic stop;
    } mxs_beat_t;

endpackage

// File: rtl/mxs_scan.sv
// Finds the lowest set mask bit whose index is at or above a start index.
// Assumes: IW can hold NREG, so a start index of NREG yields "not found".
module mxs_scan #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG) + 1
) (
    input  logic [NREG-1:0] mask_i,
    input  logic [IW-1:0]   from_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);

    logic [NREG-1:0] elig;

    // Qualify each mask bit by its position relative to the start index
    for (genvar g = 0; g < NREG; g++) begin : g_elig
        assign elig[g] = mask_i[g] && (IW'(g) >= from_i);
    end

    // Priority pick of the lowest qualified bit
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mxs_offset.sv
// Counts set mask bits below a limit index: the word offset of a resumed element.
// Assumes: the count fits IW bits (IW holds NREG).
module mxs_offset #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG) + 1
) (
    input  logic [NREG-1:0] mask_i,
    input  logic [IW-1:0]   lim_i,
    output logic [IW-1:0]   cnt_o
);

    logic [NREG-1:0] below;

    // Keep only mask bits strictly below the limit
    for (genvar g = 0; g < NREG; g++) begin : g_below
        assign below[g] = mask_i[g] && (IW'(g) < lim_i);
    end

    // Population count of the kept bits
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NREG; i++) begin
            if (below[i]) cnt_o = cnt_o + IW'(1);
        end
    end

endmodule

// File: rtl/mxs_ctrl.sv
// Sequencer controller: latches a command, computes the first address,
// applies the restart penalty, then issues one beat per unstalled cycle.
// Assumes: scan/offset results are combinational from the outputs given to them;
// RESUME_EXTRA is 1 or more.
module mxs_ctrl
    import mxs_pkg::*;
#(
    parameter int NREG         = 16,
    parameter int AW           = 32,
    parameter int WORD_BYTES   = 4,
    parameter int RESUME_EXTRA = 2,
    parameter int IW           = $clog2(NREG) + 1,
    parameter int RIW          = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            pair_i,
    input  logic            store_i,
    input  logic            resume_i,
    input  logic [IW-1:0]   resume_idx_i,
    input  logic [AW-1:0]   base_i,
    input  logic [NREG-1:0] mask_i,
    input  logic            bus_wait_i,
    input  logic            irq_i,
    input  logic            scan_found_i,
    input  logic [IW-1:0]   scan_idx_i,
    input  logic [IW-1:0]   off_cnt_i,
    output logic [NREG-1:0] mask_q_o,
    output logic [IW-1:0]   scan_from_o,
    output logic [IW-1:0]   off_lim_o,
    output logic            busy_o,
    output logic            bus_req_o,
    output logic [AW-1:0]   bus_addr_o,
    output logic            bus_we_o,
    output logic [RIW-1:0]  reg_idx_o,
    output logic            rf_we_o,
    output logic            done_o,
    output logic            halt_o,
    output logic [IW-1:0]   resume_idx_o
);

    localparam int          SH     = $clog2(WORD_BYTES);
    localparam int          CW     = (RESUME_EXTRA > 1) ? $clog2(RESUME_EXTRA) : 1;
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
    localparam logic [IW-1:0] NONE = IW'(NREG);

    mxs_state_e      state_q;
    logic [NREG-1:0] mask_q;
    logic [AW-1:0]   base_q;
    logic [AW-1:0]   addr_q;
    logic [IW-1:0]   from_q;
    logic [IW-1:0]   cur_q;
    logic [IW-1:0]   resume_q;
    logic [CW-1:0]   pen_q;
    logic            store_q;
    logic            pair_q;
    logic            rsm_q;
    logic            beat_q;
    logic            pen_end;
    mxs_beat_t       beat;

    // Restart penalty length: a single cycle needs no counter compare
    if (RESUME_EXTRA > 1) begin : g_pen_multi
        assign pen_end = (pen_q == '0);
    end else begin : g_pen_single
        assign pen_end = 1'b1;
    end

    // Scan start: command start point in setup, next index while issuing beats
    always_comb begin
        if (state_q == ST_SETUP) scan_from_o = from_q;
        else                     scan_from_o = cur_q + IW'(1);
    end

    assign mask_q_o  = mask_q;
    assign off_lim_o = from_q;

    // Decide completion, finality and interrupt stop of the current beat
    always_comb begin
        beat.complete = (state_q == ST_XFER) && !bus_wait_i;
        beat.last     = !scan_found_i || (pair_q && beat_q);
        beat.stop     = beat.complete && !beat.last && irq_i && !pair_q;
    end

    // Command latch, phase sequencing, address and resume-point registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mask_q   <= '0;
            base_q   <= '0;
            addr_q   <= '0;
            from_q   <= '0;
            cur_q    <= '0;
            resume_q <= '0;
            pen_q    <= '0;
            store_q  <= 1'b0;
            pair_q   <= 1'b0;
            rsm_q    <= 1'b0;
            beat_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mask_q  <= mask_i;
                        base_q  <= base_i;
                        store_q <= store_i;
                        pair_q  <= pair_i;
                        rsm_q   <= resume_i && !pair_i;
                        from_q  <= (resume_i && !pair_i) ? resume_idx_i : '0;
                        beat_q  <= 1'b0;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cur_q  <= scan_idx_i;
                    addr_q <= base_q + (AW'(off_cnt_i) << SH);
                    pen_q  <= CW'(RESUME_EXTRA - 1);
                    if (!scan_found_i) begin
                        resume_q <= NONE;
                        state_q  <= ST_IDLE;
                    end else if (rsm_q) begin
                        state_q <= ST_RESTART;
                    end else begin
                        state_q <= ST_XFER;
                    end
                end
                ST_RESTART: begin
                    if (pen_end) state_q <= ST_XFER;
                    else         pen_q   <= pen_q - CW'(1);
                end
                ST_XFER: begin
                    if (beat.complete) begin
                        addr_q <= addr_q + STEP;
                        beat_q <= 1'b1;
                        if (beat.last) begin
                            resume_q <= NONE;
                            state_q  <= ST_IDLE;
                        end else begin
                            resume_q <= scan_idx_i;
                            cur_q    <= scan_idx_i;
                            if (beat.stop) state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from phase and beat decision
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        bus_req_o    = (state_q == ST_XFER);
        bus_addr_o   = addr_q;
        bus_we_o     = (state_q == ST_XFER) && store_q;
        reg_idx_o    = cur_q[RIW-1:0];
        rf_we_o      = beat.complete && !store_q;
        done_o       = (beat.complete && beat.last) ||
                       ((state_q == ST_SETUP) && !scan_found_i);
        halt_o       = beat.stop;
        resume_idx_o = resume_q;
    end

endmodule

// File: rtl/mxfer_seq.sv
// Top of the multi-register transfer sequencer: controller plus the
// set-bit scanner and the resume offset counter.
// Assumes: a single clock domain and synchronous active-low reset.
module mxfer_seq #(
    parameter int NREG         = 16,
    parameter int AW           = 32,
    parameter int WORD_BYTES   = 4,
    parameter int RESUME_EXTRA = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  pair_i,
    input  logic                  store_i,
    input  logic                  resume_i,
    input  logic [$clog2(NREG):0] resume_idx_i,
    input  logic [AW-1:0]         base_i,
    input  logic [NREG-1:0]       mask_i,
    input  logic                  bus_wait_i,
    input  logic                  irq_i,
    output logic                  busy_o,
    output logic                  bus_req_o,
    output logic [AW-1:0]         bus_addr_o,
    output logic                  bus_we_o,
    output logic [$clog2(NREG)-1:0] reg_idx_o,
    output logic                  rf_we_o,
    output logic                  done_o,
    output logic                  halt_o,
    output logic [$clog2(NREG):0] resume_idx_o
);

    localparam int IW  = $clog2(NREG) + 1;
    localparam int RIW = $clog2(NREG);

    logic [NREG-1:0] mask_q;
    logic [IW-1:0]   scan_from;
    logic [IW-1:0]   scan_idx;
    logic            scan_found;
    logic [IW-1:0]   off_lim;
    logic [IW-1:0]   off_cnt;

    mxs_scan #(.NREG(NREG), .IW(IW)) u_scan (
        .mask_i  (mask_q),
        .from_i  (scan_from),
        .found_o (scan_found),
        .idx_o   (scan_idx)
    );

    mxs_offset #(.NREG(NREG), .IW(IW)) u_offset (
        .mask_i (mask_q),
        .lim_i  (off_lim),
        .cnt_o  (off_cnt)
    );

    mxs_ctrl #(
        .NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES),
        .RESUME_EXTRA(RESUME_EXTRA), .IW(IW), .RIW(RIW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pair_i       (pair_i),
        .store_i      (store_i),
        .resume_i     (resume_i),
        .resume_idx_i (resume_idx_i),
        .base_i       (base_i),
        .mask_i       (mask_i),
        .bus_wait_i   (bus_wait_i),
        .irq_i        (irq_i),
        .scan_found_i (scan_found),
        .scan_idx_i   (scan_idx),
        .off_cnt_i    (off_cnt),
        .mask_q_o     (mask_q),
        .scan_from_o  (scan_from),
        .off_lim_o    (off_lim),
        .busy_o       (busy_o),
        .bus_req_o    (bus_req_o),
        .bus_addr_o   (bus_addr_o),
        .bus_we_o     (bus_we_o),
        .reg_idx_o    (reg_idx_o),
        .rf_we_o      (rf_we_o),
        .done_o       (done_o),
        .halt_o       (halt_o),
        .resume_idx_o (resume_idx_o)
    );

endmodule

// File: rtl/mxfer_seq_chk.sv
// Temporal checks on the sequencer's ports, attached by bind.
// Assumes: the same parameter values as the bound instance.
module mxfer_seq_chk #(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wait_i,
    input logic                    irq_i,
    input logic                    busy_o,
    input logic                    bus_req_o,
    input logic [AW-1:0]           bus_addr_o,
    input logic                    bus_we_o,
    input logic [$clog2(NREG)-1:0] reg_idx_o,
    input logic                    rf_we_o,
    input logic                    done_o,
    input logic                    halt_o
);

    // R5: a beat is only presented inside a busy window
    a_r5_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> busy_o);

    // R4: the first busy cycle is the address setup, without a beat
    a_r4_setup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !bus_req_o);

    // R6: register-file writes only on completing load beats
    a_r6_rf_we_load_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (bus_req_o && !bus_wait_i && !bus_we_o));

    // R7: a stalled beat repeats unchanged
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_wait_i) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(reg_idx_o)));

    // R3: a completed non-final beat is followed by the next word and a higher index
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_wait_i && !done_o && !halt_o) |=>
            (bus_req_o && (bus_addr_o == $past(bus_addr_o) + AW'(WORD_BYTES)) &&
             (reg_idx_o > $past(reg_idx_o))));

    // R8: a stop only happens on an interrupt request
    a_r8_halt_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (irq_i && !done_o));

    // R2: after finishing or stopping, the block is idle
    a_r2_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || halt_o) |=> !busy_o);

endmodule

bind mxfer_seq mxfer_seq_chk #(
    .NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wait_i (bus_wait_i),
    .irq_i      (irq_i),
    .busy_o     (busy_o),
    .bus_req_o  (bus_req_o),
    .bus_addr_o (bus_addr_o),
    .bus_we_o   (bus_we_o),
    .reg_idx_o  (reg_idx_o),
    .rf_we_o    (rf_we_o),
    .done_o     (done_o),
    .halt_o     (halt_o)
);

// File: tb/mxfer_seq_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random commands,
// compared cycle by cycle against an expectation built from the requirements.
module mxfer_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 16;
    localparam int AW         = 32;
    localparam int WB         = 4;
    localparam int EXTRA      = 2;
    localparam int IW         = 5;
    localparam int RIW        = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            pair_i = 1'b0;
    logic            store_i = 1'b0;
    logic            resume_i = 1'b0;
    logic [IW-1:0]   resume_idx_i = '0;
    logic [AW-1:0]   base_i = '0;
    logic [NREG-1:0] mask_i = '0;
    logic            bus_wait_i = 1'b0;
    logic            irq_i = 1'b0;
    logic            busy_o, bus_req_o, bus_we_o, rf_we_o, done_o, halt_o;
    logic [AW-1:0]   bus_addr_o;
    logic [RIW-1:0]  reg_idx_o;
    logic [IW-1:0]   resume_idx_o;

    int n_chk = 0;
    int n_bad = 0;
    int e_idx[NREG];
    int e_ord[NREG];
    int e_n;

    mxfer_seq #(.NREG(NREG), .AW(AW), .WORD_BYTES(WB), .RESUME_EXTRA(EXTRA)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pair_i(pair_i),
        .store_i(store_i), .resume_i(resume_i), .resume_idx_i(resume_idx_i),
        .base_i(base_i), .mask_i(mask_i), .bus_wait_i(bus_wait_i), .irq_i(irq_i),
        .busy_o(busy_o), .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o),
        .bus_we_o(bus_we_o), .reg_idx_o(reg_idx_o), .rf_we_o(rf_we_o),
        .done_o(done_o), .halt_o(halt_o), .resume_idx_o(resume_idx_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Record one check and report a mismatch
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected element list: index and ordinal among all set bits
    task automatic plan_elems(input logic [NREG-1:0] m, input bit pr,
                              input bit rs, input int ridx);
        int pos = 0;
        e_n = 0;
        for (int i = 0; i < NREG; i++) begin
            if (m[i]) begin
                if (pr ? (e_n < 2) : (!rs || i >= ridx)) begin
                    e_idx[e_n] = i;
                    e_ord[e_n] = pos;
                    e_n++;
                end
                pos++;
            end
        end
    endtask

    // Run one command and check every cycle; returns whether it stopped early
    task automatic run_op(input logic [NREG-1:0] m, input logic [AW-1:0] b,
                          input bit st, input bit pr, input bit rs, input int ridx,
                          input int wait_pct, input int irq_pct, input bit stray,
                          output bit stopped);
        int setup;
        int k = 0;
        int cyc = 0;
        int waits = 0;
        int exp_res;
        bit fin = 0;
        bit w, q;
        string tag;
        plan_elems(m, pr, rs, ridx);
        setup = 1 + ((rs && !pr && e_n > 0) ? EXTRA : 0);
        tag = pr ? "R10" : (rs ? "R9" : "R3");
        stopped = 0;
        exp_res = NREG;
        @(negedge clk);
        start_i = 1; mask_i = m; base_i = b; store_i = st; pair_i = pr;
        resume_i = rs; resume_idx_i = IW'(ridx);
        @(negedge clk);
        start_i = stray; mask_i = ~m; base_i = ~b; resume_i = ~rs;
        for (int s = 0; s < setup; s++) begin
            irq_i = ($urandom_range(99) < 50);
            bus_wait_i = ($urandom_range(99) < 50);
            #1;
            cyc++;
            chk(busy_o === 1'b1, "R2 R5", "busy in setup", busy_o, 1);
            chk(bus_req_o === 1'b0 && rf_we_o === 1'b0 && halt_o === 1'b0,
                rs ? "R9" : "R4", "setup beat-free", bus_req_o, 0);
            chk(done_o === (e_n == 0 && s == 0), "R11", "done in setup", done_o, e_n == 0);
            @(negedge clk);
        end
        if (e_n == 0) fin = 1;
        while (!fin && cyc < 2000) begin
            w = ($urandom_range(99) < wait_pct);
            q = ($urandom_range(99) < irq_pct);
            bus_wait_i = w; irq_i = q;
            #1;
            cyc++;
            waits += w;
            chk(busy_o === 1'b1 && bus_req_o === 1'b1, "R5", "busy/req in beat", bus_req_o, 1);
            chk(bus_addr_o === b + AW'(WB * e_ord[k]), w ? "R7" : tag, "address",
                bus_addr_o, b + AW'(WB * e_ord[k]));
            chk(reg_idx_o === RIW'(e_idx[k]), w ? "R7" : tag, "register index",
                reg_idx_o, e_idx[k]);
            chk(bus_we_o === st && rf_we_o === (!w && !st), "R6", "write enables",
                {bus_we_o, rf_we_o}, {st, !w && !st});
            chk(done_o === (!w && k == e_n - 1), "R11", "done pulse", done_o, !w && k == e_n - 1);
            chk(halt_o === (!w && k < e_n - 1 && q && !pr), pr ? "R10" : "R8", "halt pulse",
                halt_o, !w && k < e_n - 1 && q && !pr);
            if (!w) begin
                if (k == e_n - 1) begin
                    fin = 1;
                end else if (q && !pr) begin
                    fin = 1; stopped = 1; exp_res = e_idx[k + 1];
                end
                k++;
            end
            @(negedge clk);
        end
        bus_wait_i = 0; irq_i = 0; start_i = 0;
        #1;
        chk(busy_o === 1'b0, "R5", "idle after end", busy_o, 0);
        chk(resume_idx_o === IW'(exp_res), stopped ? "R8" : "R11", "resume index",
            resume_idx_o, exp_res);
        if (!stopped)
            chk(cyc == setup + e_n + waits, "R4", "busy cycle count", cyc, setup + e_n + waits);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Stimulus sequence
    initial begin
        bit stp;
        logic [NREG-1:0] m;
        logic [AW-1:0] b;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(busy_o === 0 && bus_req_o === 0 && bus_we_o === 0 && rf_we_o === 0,
            "R1", "reset outputs", {busy_o, bus_req_o, bus_we_o, rf_we_o}, 0);
        chk(done_o === 0 && halt_o === 0 && resume_idx_o === '0, "R1", "reset status",
            resume_idx_o, 0);
        rst_n = 1;
        // R4 three-element load, eight-element store, no waits
        run_op(16'h0111, 32'h1000, 0, 0, 0, 0, 0, 0, 0, stp);
        run_op(16'hFF00, 32'h2000, 1, 0, 0, 0, 0, 0, 0, stp);
        // R11 empty list
        run_op(16'h0000, 32'h3000, 0, 0, 0, 0, 0, 0, 0, stp);
        // R10 doubleword: irq always on, resume flag ignored
        run_op(16'h0F0A, 32'h4000, 0, 1, 1, 9, 0, 100, 0, stp);
        run_op(16'h8001, 32'h4100, 1, 1, 0, 0, 30, 100, 1, stp);
        // R7 full mask with waits, R2 stray start
        run_op(16'hFFFF, 32'h5000, 0, 0, 0, 0, 40, 0, 1, stp);
        // R8 stop at first beat, then R9 resume from reported index
        run_op(16'h00F0, 32'h6000, 0, 0, 0, 0, 0, 100, 0, stp);
        chk(stp == 1, "R8", "stopped after first beat", stp, 1);
        run_op(16'h00F0, 32'h6000, 0, 0, 1, int'(resume_idx_o), 0, 0, 0, stp);
        // R9 resume point beyond last set bit: nothing left
        run_op(16'h000F, 32'h7000, 1, 0, 1, 12, 0, 0, 0, stp);
        // Random commands, each stopped run resumed until complete
        for (int t = 0; t < 60; t++) begin
            m = NREG'($urandom());
            b = {$urandom(), 2'b00};
            run_op(m, b, $urandom_range(1), ($urandom_range(9) == 0), 0, 0,
                   $urandom_range(40), $urandom_range(50), $urandom_range(1), stp);
            while (stp)
                run_op(m, b, 0, 0, 1, int'(resume_idx_o), $urandom_range(40),
                       $urandom_range(50), $urandom_range(1), stp);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule